// File: doc/BRIEF.md
# Tick-Driven Up-Timer and Loadable Down-Counter

This peripheral holds two count registers that share one tick from a programmable prescaler. The up-timer runs whenever the block is out of reset. It only ever counts upward and gives a one-cycle event each time it wraps to zero. The down-counter is under processor control. Software can load it with any value, start it and stop it. While it runs it counts down, and it gives a one-cycle event when it passes below zero.

Both current values drive dedicated output pins so that an external display can show them. The processor reaches the block through a small word-wide register port. A write on this port is a single-cycle strobe that the block always accepts. Reads are combinational from the address, so the port has no back-pressure and no valid/ready handshake. The two event pins are plain pulses, intended for an interrupt controller outside this block.

Register addresses: 0 reads the up-timer and ignores writes. 1 reads and loads the down-counter. 2 is control, where bit 0 is the counter run flag and all other bits read as zero. 3 holds the prescaler divisor in its low PRE_W bits. A divisor D produces one tick every D+1 clock cycles.

Top module: `tick_count_unit`

## Requirements
- R1: While reset is asserted and just after it, both counts read 0, both event pins are low, the run flag is 0, and the divisor is 0.
- R2: With divisor D in address 3, the tick, and therefore the up-timer, advances exactly once every D+1 clock cycles.
- R3: The up-timer increments by one on every tick and wraps from 0xFFFF to 0x0000. Writes to address 0 have no effect on it.
- R4: The timer event pin is high for exactly one cycle, in the cycle in which the timer first reads 0x0000 after a wrap.
- R5: The down-counter decrements by one on a tick only while the run flag (address 2 bit 0) is 1, and holds its value otherwise. A change to the run flag takes effect from the edge after the write.
- R6: The counter event pin is high for exactly one cycle, in the cycle in which the counter reads 0xFFFF after decrementing from 0x0000.
- R7: A write to address 1 loads the counter on the next edge and takes priority over a same-edge decrement. It never raises the counter event, even when the counter held 0.
- R8: Reads return the timer at address 0, the counter at address 1, the run flag in bit 0 at address 2 (other bits zero), and the zero-extended divisor at address 3.
- R9: Writing the divisor restarts the prescaler phase, so the first tick after the write comes D+1 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, accepted in the cycle it is high |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| timer_value | output | CNT_W | Current up-timer value for display |
| counter_value | output | CNT_W | Current down-counter value for display |
| timer_evt | output | 1 | One-cycle pulse on timer wrap |
| counter_evt | output | 1 | One-cycle pulse on counter rollover |

## Verification
The assertions check on every cycle that the timer only holds or steps up by one, and that each event pin coincides with the matching wrapped value and never lasts two cycles. They also check that the counter stays still while stopped and that a counter load lands exactly and silently. Only the bench scenarios can show the actual tick spacing for a given divisor and the phase restart on a divisor write. The same holds for a full 65536-step wrap, the one-edge delay of the run flag, and the register read decode.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_TIMER = 2'd0,
    RA_COUNT = 2'd1,
    RA_CTRL  = 2'd2,
    RA_PRESC = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
endpackage

// File: rtl/tcu_prescaler.sv
module tcu_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = (phase_q == divisor);

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= '0;
    else if (restart)  phase_q <= '0;
    else if (tick)     phase_q <= '0;
    else               phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tcu_up_timer.sv
module tcu_up_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] value,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value    <= '0;
      wrap_evt <= 1'b0;
    end else begin
      wrap_evt <= tick && (value == TOP);
      if (tick) value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/tcu_down_counter.sv
module tcu_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] value,
  output logic             roll_evt
);
  logic step;
  assign step = run && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value    <= '0;
      roll_evt <= 1'b0;
    end else if (load) begin
      value    <= load_val;
      roll_evt <= 1'b0;
    end else begin
      roll_evt <= step && (value == '0);
      if (step) value <= value - 1'b1;
    end
  end
endmodule

// File: rtl/tcu_regs.sv
module tcu_regs
  import tcu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  timer_val,
  input  logic [CNT_W-1:0]  count_val,
  output logic [CNT_W-1:0]  rdata,
  output logic              run,
  output logic [PRE_W-1:0]  divisor,
  output logic              div_wr,
  output logic              count_wr
);
  logic [CNT_W-1:0] div_ext;
  logic [CNT_W-1:0] ctrl_rd;
  logic             ctrl_wr;

  assign ctrl_wr  = wr && (addr == RA_CTRL);
  assign div_wr   = wr && (addr == RA_PRESC);
  assign count_wr = wr && (addr == RA_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      divisor <= '0;
    end else begin
      if (ctrl_wr) run     <= wdata[CTRL_RUN_BIT];
      if (div_wr)  divisor <= wdata[PRE_W-1:0];
    end
  end

  generate
    if (PRE_W < CNT_W) begin : g_div_pad
      assign div_ext = {{(CNT_W-PRE_W){1'b0}}, divisor};
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[CNT_W-1:PRE_W];
    end else begin : g_div_full
      assign div_ext = divisor[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_RUN_BIT] = run;
  end

  always_comb begin
    unique case (addr)
      RA_TIMER: rdata = timer_val;
      RA_COUNT: rdata = count_val;
      RA_CTRL:  rdata = ctrl_rd;
      RA_PRESC: rdata = div_ext;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_count_unit.sv
module tick_count_unit #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] timer_value,
  output logic [CNT_W-1:0] counter_value,
  output logic             timer_evt,
  output logic             counter_evt
);
  logic             tick;
  logic             run;
  logic [PRE_W-1:0] divisor;
  logic             div_wr;
  logic             count_wr;

  tcu_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (reg_addr),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .timer_val (timer_value),
    .count_val (counter_value),
    .rdata     (reg_rdata),
    .run       (run),
    .divisor   (divisor),
    .div_wr    (div_wr),
    .count_wr  (count_wr)
  );

  tcu_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .restart (div_wr),
    .tick    (tick)
  );

  tcu_up_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .value    (timer_value),
    .wrap_evt (timer_evt)
  );

  tcu_down_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (run),
    .load     (count_wr),
    .load_val (reg_wdata),
    .value    (counter_value),
    .roll_evt (counter_evt)
  );
endmodule

// File: rtl/tick_count_unit_checker.sv
module tick_count_unit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] timer_value,
  input logic [CNT_W-1:0] counter_value,
  input logic             timer_evt,
  input logic             counter_evt,
  input logic             run
);
  logic [CNT_W-1:0] all_ones;
  assign all_ones = '1;

  // R3: timer only holds or steps up by one
  p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (timer_value == $past(timer_value)) ||
             (timer_value == $past(timer_value) + 1'b1));

  // R4: timer event coincides with wrapped value and lasts one cycle
  p_timer_evt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timer_evt |-> (timer_value == '0));
  p_timer_evt_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timer_evt |=> !timer_evt);

  // R5: counter holds while stopped and not loaded
  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(reg_wr && reg_addr == 2'd1)) |=> $stable(counter_value));

  // R6: counter event coincides with rolled value and lasts one cycle
  p_count_evt_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    counter_evt |-> (counter_value == all_ones));
  p_count_evt_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    counter_evt |=> !counter_evt);

  // R7: load lands exactly and raises no event
  p_count_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=>
      (counter_value == $past(reg_wdata)) && !counter_evt);
endmodule

bind tick_count_unit tick_count_unit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_addr      (reg_addr),
  .reg_wr        (reg_wr),
  .reg_wdata     (reg_wdata),
  .timer_value   (timer_value),
  .counter_value (counter_value),
  .timer_evt     (timer_evt),
  .counter_evt   (counter_evt),
  .run           (run)
);

// File: tb/test_tick_count_unit.sv
`timescale 1ns/1ps
module test_tick_count_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [15:0] timer_value;
  logic [15:0] counter_value;
  logic        timer_evt;
  logic        counter_evt;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_count_unit i_tick_count_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .timer_value   (timer_value),
    .counter_value (counter_value),
    .timer_evt     (timer_evt),
    .counter_evt   (counter_evt)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive at a negedge, one posedge passes, returns at the next negedge
  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    step(2);
    check("R1 timer in reset", timer_value, 16'h0);
    check("R1 counter in reset", counter_value, 16'h0);
    check("R1 events in reset", {14'd0, timer_evt, counter_evt}, 16'h0);
    bus_read(2'd2, v); check("R1 run flag", v, 16'h0);
    bus_read(2'd3, v); check("R1 divisor", v, 16'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_prescale();
    logic [15:0] t0, t1, v;
    bus_write(2'd3, 16'h0003);
    t0 = timer_value;
    bus_read(2'd3, v); check("R8 divisor readback", v, 16'h0003);
    step(3); check("R2 no tick before D+1", timer_value, t0);
    step(1); check("R2 tick at D+1", timer_value, t0 + 16'd1);
    step(8); check("R2 two more periods", timer_value, t0 + 16'd3);
    step(2);
    bus_write(2'd3, 16'h0003);
    t1 = timer_value;
    step(1); check("R9 phase restarted", timer_value, t1);
    step(3); check("R9 tick D+1 after write", timer_value, t1 + 16'd1);
    bus_write(2'd3, 16'h0000);
    t0 = timer_value;
    step(5); check("R2 divisor zero ticks every cycle", timer_value, t0 + 16'd5);
  endtask

  task automatic t_timer_ignore_write();
    logic [15:0] t0, v;
    t0 = timer_value;
    bus_write(2'd0, 16'h1234);
    check("R3 write to timer ignored", timer_value, t0 + 16'd1);
    bus_read(2'd0, v); check("R8 timer readback", v, timer_value);
  endtask

  task automatic t_timer_wrap();
    logic [15:0] t0;
    t0 = timer_value;
    step(int'(16'hFFFF - t0));
    check("R3 timer at top", timer_value, 16'hFFFF);
    check("R4 no event before wrap", {15'd0, timer_evt}, 16'h0);
    step(1);
    check("R3 timer wraps to zero", timer_value, 16'h0);
    check("R4 event on wrap", {15'd0, timer_evt}, 16'h1);
    step(1);
    check("R3 timer after wrap", timer_value, 16'h1);
    check("R4 event one cycle", {15'd0, timer_evt}, 16'h0);
  endtask

  task automatic t_counter_run_roll();
    logic [15:0] v;
    bus_write(2'd1, 16'h0002);
    check("R7 load value", counter_value, 16'h0002);
    bus_write(2'd2, 16'h0001);
    check("R5 run takes effect next edge", counter_value, 16'h0002);
    bus_read(2'd2, v); check("R8 run flag readback", v, 16'h0001);
    step(1); check("R5 decrement", counter_value, 16'h0001);
    step(1); check("R5 reaches zero", counter_value, 16'h0000);
    check("R6 no event at zero", {15'd0, counter_evt}, 16'h0);
    step(1); check("R6 rollover value", counter_value, 16'hFFFF);
    check("R6 event on rollover", {15'd0, counter_evt}, 16'h1);
    step(1); check("R6 after rollover", counter_value, 16'hFFFE);
    check("R6 event one cycle", {15'd0, counter_evt}, 16'h0);
    bus_write(2'd2, 16'h0000);
    check("R5 stop write edge still runs", counter_value, 16'hFFFD);
    step(5); check("R5 holds while stopped", counter_value, 16'hFFFD);
  endtask

  task automatic t_write_priority();
    logic [15:0] v;
    bus_write(2'd2, 16'h0001);
    check("R5 held on run write edge", counter_value, 16'hFFFD);
    bus_write(2'd1, 16'h0000);
    check("R7 load beats decrement", counter_value, 16'h0000);
    check("R7 no event on load", {15'd0, counter_evt}, 16'h0);
    bus_write(2'd1, 16'h0007);
    check("R7 load over zero", counter_value, 16'h0007);
    check("R7 no event when loading from zero", {15'd0, counter_evt}, 16'h0);
    step(1); check("R5 decrement after load", counter_value, 16'h0006);
    bus_read(2'd1, v); check("R8 counter readback", v, 16'h0006);
    bus_write(2'd3, 16'h0001);
    check("R5 tick on divisor write edge", counter_value, 16'h0005);
    step(1); check("R5 no decrement without tick", counter_value, 16'h0005);
    step(1); check("R5 decrement on tick", counter_value, 16'h0004);
    bus_write(2'd2, 16'h0000);
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    t_prescale();
    t_timer_ignore_write();
    t_timer_wrap();
    t_counter_run_roll();
    t_write_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1500us;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule